// File: doc/BRIEF.md
# Pulse-Coded Voltage Setpoint Controller

This block turns a one-wire command into a stepped regulator setpoint. A host holds a strobe line high and toggles a serial clock. The number of serial-clock falling edges seen during that strobe pulse selects the action:

- one edge lowers the live setpoint code by one step;
- two edges raise it by one step;
- three or more edges start a recovery. Recovery walks the code back to the programmed value one step at a time.

Each step occupies a step period whose length in system clocks comes from an input. Jog commands that arrive while a period is running are discarded. A recovery request is held until it can be served.

The live code feeds the regulator's digital control. The programmed code is an input that the block only reads. When the block is disabled, the live code follows the programmed code and strobe activity is ignored. The strobe and serial clock are asynchronous to the system clock and are brought in through two-flop synchronisers.

Top module: `spc_setpoint_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first step, `setpoint_o` equals `prog_code_i` and `busy_o` is low.
- R2: A strobe pulse with exactly one serial-clock falling edge lowers `setpoint_o` by one code. The change is committed when the strobe falls.
- R3: A strobe pulse whose second falling edge is detected raises `setpoint_o` by one code. The change happens before the strobe falls.
- R4: A third (or later) falling edge within one strobe pulse starts a recovery. The code then moves one code per step period toward `prog_code_i`, up or down as needed, and stops when the two are equal.
- R5: Consecutive steps are exactly `step_len_i` clock cycles apart, with 0 treated as 1. `busy_o` is high in every cycle after a step in which a further step cannot yet start.
- R6: A jog (one- or two-edge decode) that arrives while `busy_o` is high is dropped and not stored for later.
- R7: A recovery request detected while `busy_o` is high is kept. It is served as soon as the period ends, even though the up-jog decode of the same pulse was dropped.
- R8: The code saturates at 0 and at 2^CODE_W-1 (31 by default). A jog beyond either limit changes nothing and leaves `busy_o` low.
- R9: While `en` is low, strobe pulses have no effect, `busy_o` is low, and `setpoint_o` follows `prog_code_i`.
- R10: A strobe pulse with no serial-clock falling edge changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Command decoding enable; low forces tracking of the programmed code |
| strobe_i | input | 1 | Asynchronous command strobe |
| sclk_i | input | 1 | Asynchronous serial clock whose falling edges are counted |
| prog_code_i | input | CODE_W | Programmed setpoint code |
| step_len_i | input | PER_W | Step period in system clock cycles |
| setpoint_o | output | CODE_W | Live setpoint code |
| busy_o | output | 1 | Step period running, jogs dropped |

## Verification
The bench builds the block with CODE_W=5 and PER_W=8, so both saturation rails are only a few jogs away. It then switches `step_len_i` between 12, 0 and 60 at run time:

- With 0, recovery steps land on consecutive cycles, which exercises the minimum spacing.
- With 60, one step period outlasts several whole strobe pulses. That makes dropped jogs and a pending recovery behind a running period directly observable.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_DOWN    = 2'd1,
    CMD_UP      = 2'd2,
    CMD_RECOVER = 2'd3
  } spc_cmd_e;
endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spc_pulse_decoder.sv
module spc_pulse_decoder
  import spc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     strobe_s,
  input  logic     sclk_s,
  output spc_cmd_e cmd
);
  localparam logic [1:0] CNT_SAT = 2'd3;

  logic       strobe_q, sclk_q;
  logic [1:0] cnt_q, cnt_d;
  logic       sclk_fall, stb_rise, stb_fall;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign stb_rise  = strobe_s & ~strobe_q;
  assign stb_fall  = strobe_q & ~strobe_s;

  always_comb begin
    cnt_d = cnt_q;
    cmd   = CMD_NONE;
    if (!en) begin
      cnt_d = '0;
    end else if (stb_rise) begin
      cnt_d = '0;
    end else if (strobe_s && sclk_fall) begin
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 2'd1;
      if (cnt_q == 2'd1) cmd = CMD_UP;
      if (cnt_q == 2'd2) cmd = CMD_RECOVER;
    end else if (stb_fall && cnt_q == 2'd1) begin
      cmd = CMD_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      sclk_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= strobe_s;
      sclk_q   <= sclk_s;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/spc_step_engine.sv
module spc_step_engine
  import spc_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  spc_cmd_e          cmd,
  input  logic [CODE_W-1:0] prog_code,
  input  logic [PER_W-1:0]  step_len,
  output logic [CODE_W-1:0] setpoint,
  output logic              busy
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [PER_W-1:0]  PER_ONE  = PER_W'(1);

  logic [CODE_W-1:0] sp_q, sp_d, base;
  logic [PER_W-1:0]  timer_q, timer_d, period;
  logic              track_q, track_d, rec_q, rec_d;
  logic              ready, rec_want, step, dir_up;

  assign base     = track_q ? prog_code : sp_q;
  assign period   = (step_len == '0) ? PER_ONE : step_len;
  assign ready    = (timer_q <= PER_ONE);
  assign rec_want = rec_q | (cmd == CMD_RECOVER);

  always_comb begin
    sp_d    = sp_q;
    timer_d = (timer_q != '0) ? timer_q - PER_ONE : '0;
    track_d = track_q;
    rec_d   = rec_want;
    step    = 1'b0;
    dir_up  = 1'b0;
    if (!en) begin
      track_d = 1'b1;
      timer_d = '0;
      rec_d   = 1'b0;
    end else if (ready) begin
      if (rec_want) begin
        if (base == prog_code) begin
          rec_d = 1'b0;
        end else begin
          step   = 1'b1;
          dir_up = (base < prog_code);
        end
      end else if (cmd == CMD_UP && base != CODE_MAX) begin
        step   = 1'b1;
        dir_up = 1'b1;
      end else if (cmd == CMD_DOWN && base != '0) begin
        step   = 1'b1;
        dir_up = 1'b0;
      end
    end
    if (step) begin
      sp_d    = dir_up ? base + 1'b1 : base - 1'b1;
      track_d = 1'b0;
      timer_d = period;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      timer_q <= '0;
      track_q <= 1'b1;
      rec_q   <= 1'b0;
    end else begin
      sp_q    <= sp_d;
      timer_q <= timer_d;
      track_q <= track_d;
      rec_q   <= rec_d;
    end
  end

  assign setpoint = base;
  assign busy     = (timer_q > PER_ONE);
endmodule

// File: rtl/spc_setpoint_ctrl.sv
module spc_setpoint_ctrl
  import spc_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              strobe_i,
  input  logic              sclk_i,
  input  logic [CODE_W-1:0] prog_code_i,
  input  logic [PER_W-1:0]  step_len_i,
  output logic [CODE_W-1:0] setpoint_o,
  output logic              busy_o
);
  logic [1:0] raw_in, sync_out;
  spc_cmd_e   cmd;

  assign raw_in = {strobe_i, sclk_i};

  spc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  spc_pulse_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .en(en),
    .strobe_s(sync_out[1]), .sclk_s(sync_out[0]), .cmd(cmd)
  );

  spc_step_engine #(.CODE_W(CODE_W), .PER_W(PER_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd(cmd),
    .prog_code(prog_code_i), .step_len(step_len_i),
    .setpoint(setpoint_o), .busy(busy_o)
  );
endmodule

// File: rtl/spc_setpoint_ctrl_chk.sv
module spc_setpoint_ctrl_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [CODE_W-1:0] prog_code_i,
  input logic [CODE_W-1:0] setpoint_o,
  input logic              busy_o
);
  localparam int CMAX = (1 << CODE_W) - 1;

  AST_RESET_TRACKS: assert property (@(posedge clk)
    !rst_n |-> (setpoint_o == prog_code_i && !busy_o)); // R1

  AST_ONE_CODE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $stable(prog_code_i)) |->
      (int'(setpoint_o) == int'($past(setpoint_o)) ||
       int'(setpoint_o) == int'($past(setpoint_o)) + 1 ||
       int'(setpoint_o) == int'($past(setpoint_o)) - 1)); // R4

  AST_NO_STEP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $stable(prog_code_i) && setpoint_o != $past(setpoint_o))
      |-> !$past(busy_o)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $stable(prog_code_i)) |->
      !((int'($past(setpoint_o)) == CMAX && setpoint_o == '0) ||
        ($past(setpoint_o) == '0 && int'(setpoint_o) == CMAX))); // R8

  AST_OFF_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (setpoint_o == prog_code_i && !busy_o)); // R9
endmodule

bind spc_setpoint_ctrl spc_setpoint_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .prog_code_i(prog_code_i),
  .setpoint_o(setpoint_o), .busy_o(busy_o)
);

// File: tb/sim_spc_setpoint_ctrl.sv
`timescale 1ns/1ps
module sim_spc_setpoint_ctrl;
  localparam int CW = 5;
  localparam int PW = 8;

  typedef struct {
    int    val;
    int    gap;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          en = 1'b1;
  logic          strobe = 1'b0;
  logic          sclk = 1'b0;
  logic [CW-1:0] prog = 5'd26;
  logic [PW-1:0] step_len = 8'd12;
  logic [CW-1:0] setpoint;
  logic          busy;

  exp_t          q[$];
  int            n_chk = 0;
  int            n_err = 0;
  int            since = 0;
  logic [CW-1:0] prev;
  bit            mon_on = 1'b0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  spc_setpoint_ctrl #(.CODE_W(CW), .PER_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .strobe_i(strobe), .sclk_i(sclk),
    .prog_code_i(prog), .step_len_i(step_len),
    .setpoint_o(setpoint), .busy_o(busy)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int val, int gap, string tag);
    exp_t e;
    e.val = val; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // strobe pulse carrying n falling edges; early >= 0 checks R3 before strobe falls
  task automatic pulse(int n, int early);
    strobe = 1'b1;
    wait_cyc(4);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; wait_cyc(3);
      sclk = 1'b0; wait_cyc(3);
    end
    wait_cyc(6);
    if (early >= 0) chk(int'(setpoint) == early, "R3 up before strobe falls", int'(setpoint), early);
    strobe = 1'b0;
    wait_cyc(6);
  endtask

  // monitor: pops expected values as the live code changes
  always @(negedge clk) begin
    if (mon_on) begin
      since++;
      if (setpoint !== prev) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6/R10 unexpected change", int'(setpoint), int'(prev));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(setpoint) == e.val, e.tag, int'(setpoint), e.val);
          if (e.gap > 0) chk(since == e.gap, {e.tag, " step spacing"}, since, e.gap);
        end
        prev  = setpoint;
        since = 0;
      end
    end
  end

  task automatic finish_run();
    foreach (q[i]) chk(1'b0, {q[i].tag, " missing change"}, -1, q[i].val);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    wait_cyc(4);
    chk(setpoint == 5'd26, "R1 reset code", int'(setpoint), 26);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    prev = setpoint;
    mon_on = 1'b1;
    wait_cyc(5);
    chk(setpoint == 5'd26, "R1 after reset", int'(setpoint), 26);

    // R10: no edges
    pulse(0, -1); wait_cyc(20);
    chk(setpoint == 5'd26, "R10 zero edges", int'(setpoint), 26);

    // R2 / R3 jogs, period 12
    push(25, 0, "R2"); pulse(1, -1); wait_cyc(20);
    push(26, 0, "R3"); pulse(2, 26);
    push(27, 0, "R3"); pulse(2, 27);
    push(28, 0, "R3"); pulse(2, 28); wait_cyc(20);

    // R4 recovery downward (edge 2 of the pulse steps up first)
    push(29, 0, "R3"); push(28, 12, "R4"); push(27, 12, "R4"); push(26, 12, "R4");
    pulse(3, -1); wait_cyc(60);
    chk(setpoint == 5'd26, "R4 back at programmed", int'(setpoint), 26);

    // R4 recovery upward with four edges
    push(25, 0, "R2"); pulse(1, -1);
    push(24, 0, "R2"); pulse(1, -1); wait_cyc(20);
    push(25, 0, "R3"); push(26, 12, "R4");
    pulse(4, -1); wait_cyc(40);
    chk(setpoint == 5'd26, "R4 upward recovery", int'(setpoint), 26);

    // R5 length 0 acts as 1
    step_len = 8'd0;
    push(27, 0, "R3"); pulse(2, 27);
    push(28, 0, "R3"); pulse(2, 28);
    push(29, 0, "R3"); pulse(2, 29);
    push(30, 0, "R3"); push(29, 0, "R4"); push(28, 1, "R5"); push(27, 1, "R5"); push(26, 1, "R5");
    pulse(3, -1); wait_cyc(20);

    // R5 / R6 long period: later jogs dropped
    step_len = 8'd60;
    push(27, 0, "R3"); pulse(2, 27);
    chk(busy == 1'b1, "R5 busy during period", int'(busy), 1);
    pulse(2, -1); pulse(1, -1);
    wait_cyc(60);
    chk(setpoint == 5'd27, "R6 jogs dropped", int'(setpoint), 27);
    chk(busy == 1'b0, "R5 busy clears", int'(busy), 0);
    push(28, 0, "R3"); push(27, 60, "R4"); push(26, 60, "R4");
    pulse(3, -1); wait_cyc(150);

    // R7 recovery behind a running period
    push(27, 0, "R3"); pulse(2, 27);
    push(26, 60, "R7"); pulse(3, -1); wait_cyc(100);
    chk(setpoint == 5'd26, "R7 pending recovery served", int'(setpoint), 26);

    // R9 disabled, then R8 top rail
    en = 1'b0; wait_cyc(2);
    push(31, 0, "R9"); prog = 5'd31; wait_cyc(3);
    pulse(2, -1);
    chk(setpoint == 5'd31, "R9 strobe ignored", int'(setpoint), 31);
    chk(busy == 1'b0, "R9 busy low", int'(busy), 0);
    en = 1'b1; wait_cyc(3);
    pulse(2, -1);
    chk(setpoint == 5'd31, "R8 top rail", int'(setpoint), 31);
    chk(busy == 1'b0, "R8 no period at top", int'(busy), 0);
    push(30, 0, "R2"); pulse(1, -1); wait_cyc(80);
    push(31, 0, "R3"); pulse(3, -1); wait_cyc(80);

    // R8 bottom rail
    en = 1'b0; wait_cyc(2);
    push(0, 0, "R9"); prog = 5'd0; wait_cyc(3);
    en = 1'b1; wait_cyc(3);
    pulse(1, -1);
    chk(setpoint == 5'd0, "R8 bottom rail", int'(setpoint), 0);
    chk(busy == 1'b0, "R8 no period at bottom", int'(busy), 0);
    push(1, 0, "R3"); pulse(2, 1); wait_cyc(80);
    push(2, 0, "R3"); push(1, 60, "R4"); push(0, 60, "R4");
    pulse(3, -1); wait_cyc(150);
    chk(setpoint == 5'd0, "R4 recovery to zero", int'(setpoint), 0);

    // R9 tracking with commands present
    en = 1'b0; wait_cyc(2);
    push(10, 0, "R9"); prog = 5'd10; wait_cyc(3);
    pulse(3, -1); wait_cyc(10);
    chk(setpoint == 5'd10, "R9 tracks programmed", int'(setpoint), 10);

    wait_cyc(10);
    done = 1'b1;
    finish_run();
  end
endmodule